// File: doc/BRIEF.md
# Coefficient Broadcast Output Stage for a Down-Sampled Linear Image Filter

This block rebuilds full-resolution pixels from filter coefficients that were worked out on a coarse grid. Upstream logic produces one signed linear pair (gain, offset) for every 4×4 tile of the image. This block takes that pair from a valid/ready stream and keeps it in a holding register. It then receives the 16 guide pixels of the same tile as one wide beat. It evaluates `gain·pixel + offset` in 16 parallel lanes and emits all 16 results as one output beat. Each coefficient beat therefore turns into sixteen output pixels, and no interpolation between tiles is needed.

Gain and offset are signed fixed-point values with 12 fractional bits, stored in 16 bits. The offset is expressed in normalised intensity units, so one unit equals 256 pixel steps. Guide and result pixels are 8-bit unsigned. The result is rounded half-up and then clamped to the pixel range. The output stage is a single register. When the output is stalled, both window issue and coefficient intake stop, and nothing is lost. When nothing stalls, the block completes one tile per clock.

Top module: `guided_bcast_out`

## Requirements
- R1: Out of reset, `res_valid` is 0, `coef_ready` is 1 and `win_ready` is 0.
- R2: Each result lane equals floor((gain·p + offset·256 + 2048) / 4096), with gain and offset read as signed 16-bit two's complement values and p as the guide pixel of that lane, then clamped per R3.
- R3: A lane result below 0 is output as 0, and a lane result above 255 is output as 255.
- R4: Lane k of `res_pix` (bits 8k+7..8k) is computed only from lane k of `win_pix`, using the coefficient pair shared by the whole window. Lanes are in raster order (k = row·4 + col).
- R5: `win_ready` stays low while no coefficient pair is held, so a window is never issued without coefficients.
- R6: A held coefficient pair is used for exactly one window. After that window is issued, the next window waits for a newly accepted pair, and a new pair may be accepted in the same cycle the old one is used.
- R7: A window accepted on a clock edge produces its results on `res_pix`, with `res_valid` high, right after that same edge.
- R8: While `res_valid` is high and `res_ready` is low, `res_valid` and `res_pix` hold their values, `win_ready` is low, and a held coefficient pair is kept (`coef_ready` stays low).
- R9: With both inputs always valid and `res_ready` always high, N tiles give N results on N consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| coef_valid | input | 1 | Coefficient pair offered |
| coef_ready | output | 1 | Coefficient pair accepted on this edge if valid |
| coef_gain | input | 16 | Signed gain, 12 fractional bits |
| coef_offset | input | 16 | Signed offset, 12 fractional bits, normalised intensity |
| win_valid | input | 1 | Guide window offered |
| win_ready | output | 1 | Guide window accepted on this edge if valid |
| win_pix | input | 128 | 16 guide pixels, lane k at bits 8k+7..8k |
| res_valid | output | 1 | Result window present |
| res_ready | input | 1 | Downstream takes the result window |
| res_pix | output | 128 | 16 result pixels, same lane order as `win_pix` |

## Verification
The bench streams a table of coefficient and tile pairs and checks every lane against an independent arithmetic model. The table covers the identity gain, an inverting gain with a one-unit offset, half-gain rounding at the 0.5 boundary, and tiny negative gains. A design that truncated instead of rounding, or that clamped the wrong way, would show up on these exact boundary values. A single hot lane in an otherwise dark tile catches lanes that are swapped or share a pixel. A window offered with no pair held, and a second window offered after its pair was spent, both catch a design that reuses stale coefficients or issues a window without any. A stalled output with new inputs waiting catches a design that overwrites or drops the pending result. A back-to-back stream catches a design that loses throughput by inserting a bubble between pairs.

// File: rtl/gof_pkg.sv
package gof_pkg;
    // Tile geometry and number formats shared by the output stage.
    localparam int WIN_SIDE = 4;
    localparam int PIX_W    = 8;
    localparam int COEF_W   = 16;
    localparam int FRAC_W   = 12;
    localparam int LANES    = WIN_SIDE * WIN_SIDE;

    // Handshake events of one cycle at the block's input side.
    typedef struct packed {
        logic coef_load;
        logic win_fire;
    } step_t;
endpackage

// File: rtl/gof_coef_hold.sv
module gof_coef_hold #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_data,
    input  logic         use_pair,
    output logic         full,
    output logic [W-1:0] data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
            data <= '0;
        end else begin
            if (load) begin
                full <= 1'b1;
                data <= load_data;
            end else if (use_pair) begin
                full <= 1'b0;
            end
        end
    end

    // R6: a pair that was used and not replaced is gone on the next cycle
    p_single_use_r6: assert property (@(posedge clk) disable iff (rst)
        (use_pair && !load) |=> !full);
    // R5: the pair is only used while one is held
    p_use_needs_pair_r5: assert property (@(posedge clk) disable iff (rst)
        use_pair |-> full);
endmodule

// File: rtl/gof_lane.sv
module gof_lane #(
    parameter int COEF_W = 16,
    parameter int PIX_W  = 8,
    parameter int FRAC_W = 12
) (
    input  logic signed [COEF_W-1:0] gain,
    input  logic signed [COEF_W-1:0] offset,
    input  logic        [PIX_W-1:0]  pix,
    output logic        [PIX_W-1:0]  res
);
    localparam int ACC_W = COEF_W + PIX_W + 2;
    localparam logic signed [ACC_W-1:0] RND  = ACC_W'(1) <<< (FRAC_W - 1);
    localparam logic signed [ACC_W-1:0] PMAX = ACC_W'((1 << PIX_W) - 1);

    logic signed [ACC_W-1:0] gain_x, pix_x, prod, offs, acc, shf;

    always_comb begin
        gain_x = ACC_W'(gain);
        pix_x  = ACC_W'({1'b0, pix});
        prod   = gain_x * pix_x;
        offs   = ACC_W'(offset) <<< PIX_W;
        acc    = prod + offs + RND;
        shf    = acc >>> FRAC_W;
        if (shf[ACC_W-1])
            res = '0;
        else if (shf > PMAX)
            res = '1;
        else
            res = shf[PIX_W-1:0];
    end
endmodule

// File: rtl/gof_out_reg.sv
module gof_out_reg #(
    parameter int W = 128
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] din,
    input  logic         ready,
    output logic         valid,
    output logic [W-1:0] dout
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            dout  <= '0;
        end else if (load) begin
            valid <= 1'b1;
            dout  <= din;
        end else if (ready) begin
            valid <= 1'b0;
        end
    end

    // R8: a stalled result stays put
    p_stall_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (valid && !ready) |=> (valid && $stable(dout)));
endmodule

// File: rtl/guided_bcast_out.sv
module guided_bcast_out
    import gof_pkg::*;
#(
    parameter int P_WIN_SIDE = gof_pkg::WIN_SIDE,
    parameter int P_PIX_W    = gof_pkg::PIX_W,
    parameter int P_COEF_W   = gof_pkg::COEF_W,
    parameter int P_FRAC_W   = gof_pkg::FRAC_W,
    localparam int NL        = P_WIN_SIDE * P_WIN_SIDE,
    localparam int WIN_W     = NL * P_PIX_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                coef_valid,
    output logic                coef_ready,
    input  logic [P_COEF_W-1:0] coef_gain,
    input  logic [P_COEF_W-1:0] coef_offset,
    input  logic                win_valid,
    output logic                win_ready,
    input  logic [WIN_W-1:0]    win_pix,
    output logic                res_valid,
    input  logic                res_ready,
    output logic [WIN_W-1:0]    res_pix
);
    logic                  coef_full;
    logic [2*P_COEF_W-1:0] pair_q;
    logic                  out_free;
    step_t                 step;
    logic [WIN_W-1:0]      lane_res;

    always_comb begin
        out_free       = !res_valid || res_ready;
        win_ready      = coef_full && out_free;
        step.win_fire  = win_valid && win_ready;
        coef_ready     = !coef_full || step.win_fire;
        step.coef_load = coef_valid && coef_ready;
    end

    gof_coef_hold #(.W(2 * P_COEF_W)) u_hold (
        .clk       (clk),
        .rst       (rst),
        .load      (step.coef_load),
        .load_data ({coef_gain, coef_offset}),
        .use_pair  (step.win_fire),
        .full      (coef_full),
        .data      (pair_q)
    );

    for (genvar k = 0; k < NL; k++) begin : g_lane
        gof_lane #(
            .COEF_W (P_COEF_W),
            .PIX_W  (P_PIX_W),
            .FRAC_W (P_FRAC_W)
        ) u_lane (
            .gain   (pair_q[2*P_COEF_W-1:P_COEF_W]),
            .offset (pair_q[P_COEF_W-1:0]),
            .pix    (win_pix[k*P_PIX_W +: P_PIX_W]),
            .res    (lane_res[k*P_PIX_W +: P_PIX_W])
        );
    end

    gof_out_reg #(.W(WIN_W)) u_out (
        .clk   (clk),
        .rst   (rst),
        .load  (step.win_fire),
        .din   (lane_res),
        .ready (res_ready),
        .valid (res_valid),
        .dout  (res_pix)
    );

    // R7: an accepted window is presented on the next cycle
    p_issue_next_r7: assert property (@(posedge clk) disable iff (rst)
        (win_valid && win_ready) |=> res_valid);
    // R8: a held pair survives an output stall
    p_keep_pair_r8: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_ready && coef_full) |=> coef_full);
    // R8: no window is taken while the output is stalled
    p_no_issue_stall_r8: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_ready) |-> !win_ready);
endmodule

// File: tb/tb_guided_bcast_out.sv
`timescale 1ns/1ps
module tb_guided_bcast_out;
    logic         clk = 1'b0;
    logic         rst;
    logic         coef_valid, coef_ready;
    logic [15:0]  coef_gain, coef_offset;
    logic         win_valid, win_ready;
    logic [127:0] win_pix;
    logic         res_valid, res_ready;
    logic [127:0] res_pix;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    guided_bcast_out dut (
        .clk(clk), .rst(rst),
        .coef_valid(coef_valid), .coef_ready(coef_ready),
        .coef_gain(coef_gain), .coef_offset(coef_offset),
        .win_valid(win_valid), .win_ready(win_ready), .win_pix(win_pix),
        .res_valid(res_valid), .res_ready(res_ready), .res_pix(res_pix)
    );

    // Vector table: gain, offset, first pixel, pixel step, expected lane 0
    localparam int NV = 8;
    localparam logic [15:0] TG [NV] = '{16'd4096, 16'hF000, 16'd2048, 16'd8192,
                                        16'd4096, 16'd1365, 16'd4096, 16'hFFFF};
    localparam logic [15:0] TB [NV] = '{16'd0, 16'd4096, 16'd0, 16'd0,
                                        16'hF000, 16'd410, 16'd128, 16'd16};
    localparam int TBASE [NV] = '{0, 0, 3, 200, 100, 90, 250, 255};
    localparam int TSTEP [NV] = '{17, 16, 1, 1, 10, 7, 1, 3};
    localparam int TEXP0 [NV] = '{0, 255, 2, 255, 0, 56, 255, 1};

    logic [15:0]  sg [NV];
    logic [15:0]  so [NV];
    logic [127:0] sw [NV];

    function automatic int model(input logic [15:0] g, input logic [15:0] o, input int p);
        int s;
        s = int'($signed(g)) * p + int'($signed(o)) * 256 + 2048;
        s = s >>> 12;
        if (s < 0) s = 0;
        if (s > 255) s = 255;
        return s;
    endfunction

    function automatic logic [127:0] make_win(input int base, input int step);
        logic [127:0] w;
        for (int k = 0; k < 16; k++) w[k*8 +: 8] = 8'((base + k * step) & 255);
        return w;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic check_window(input string tag, input logic [15:0] g,
                                input logic [15:0] o, input logic [127:0] w);
        for (int k = 0; k < 16; k++)
            chk($sformatf("%s lane %0d", tag, k), int'(res_pix[k*8 +: 8]),
                model(g, o, int'(w[k*8 +: 8])));
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Offer a pair and wait until it is taken; called at a negedge
    task automatic send_coef(input logic [15:0] g, input logic [15:0] o);
        coef_valid = 1'b1; coef_gain = g; coef_offset = o;
        #1;
        while (!coef_ready) begin @(posedge clk); @(negedge clk); #1; end
        @(posedge clk); @(negedge clk);
        coef_valid = 1'b0;
    endtask

    task automatic send_win(input logic [127:0] w);
        win_valid = 1'b1; win_pix = w;
        #1;
        while (!win_ready) begin @(posedge clk); @(negedge clk); #1; end
        @(posedge clk); @(negedge clk);
        win_valid = 1'b0;
    endtask

    // Stream n table entries with both inputs held valid
    task automatic run_stream(input int n);
        int ci, wi, ri, cyc, first, last;
        bit cf, wf;
        ci = 0; wi = 0; ri = 0; cyc = 0; first = -1; last = -1;
        res_ready = 1'b1;
        while (ri < n && cyc < 100) begin
            if (res_valid) begin
                check_window($sformatf("R2 R3 R4 vector %0d", ri), sg[ri], so[ri], sw[ri]);
                chk($sformatf("R2 vector %0d table lane 0", ri), int'(res_pix[7:0]), TEXP0[ri]);
                if (first < 0) first = cyc;
                last = cyc;
                ri++;
            end
            coef_valid = (ci < n);
            coef_gain  = sg[(ci < n) ? ci : 0];
            coef_offset = so[(ci < n) ? ci : 0];
            win_valid  = (wi < n);
            win_pix    = sw[(wi < n) ? wi : 0];
            #1;
            cf = coef_valid && coef_ready;
            wf = win_valid && win_ready;
            @(posedge clk); @(negedge clk);
            if (cf) ci++;
            if (wf) wi++;
            cyc++;
        end
        coef_valid = 1'b0; win_valid = 1'b0;
        chk("R9 results delivered", ri, n);
        chk("R9 consecutive result cycles", last - first, n - 1);
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [127:0] w1, w2;
        rst = 1'b1; coef_valid = 1'b0; win_valid = 1'b0; res_ready = 1'b1;
        coef_gain = '0; coef_offset = '0; win_pix = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        @(posedge clk); @(negedge clk);

        // R1 reset state
        chk("R1 res_valid", int'(res_valid), 0);
        chk("R1 coef_ready", int'(coef_ready), 1);
        chk("R1 win_ready", int'(win_ready), 0);

        // R5: window offered with no pair held
        win_valid = 1'b1; win_pix = make_win(10, 5);
        for (int i = 0; i < 3; i++) begin
            #1;
            chk("R5 win_ready without pair", int'(win_ready), 0);
            chk("R5 no result without pair", int'(res_valid), 0);
            @(posedge clk); @(negedge clk);
        end
        win_valid = 1'b0;

        // R6 and R7: one pair serves one window only
        w1 = make_win(10, 5);
        send_coef(16'd4096, 16'd0);
        send_win(w1);
        chk("R7 res_valid after issue", int'(res_valid), 1);
        check_window("R7 first window", 16'd4096, 16'd0, w1);
        w2 = make_win(0, 13);
        win_valid = 1'b1; win_pix = w2;
        for (int i = 0; i < 3; i++) begin
            #1;
            chk("R6 spent pair blocks window", int'(win_ready), 0);
            @(posedge clk); @(negedge clk);
        end
        win_valid = 1'b0;
        send_coef(16'hF000, 16'd4096);
        send_win(w2);
        check_window("R6 window takes new pair", 16'hF000, 16'd4096, w2);

        // R4: single hot lane
        w1 = '0; w1[127:120] = 8'd255;
        send_coef(16'd4096, 16'd0);
        send_win(w1);
        check_window("R4 hot lane 15", 16'd4096, 16'd0, w1);
        w1 = '0; w1[7:0] = 8'd77;
        send_coef(16'd4096, 16'd0);
        send_win(w1);
        check_window("R4 hot lane 0", 16'd4096, 16'd0, w1);

        // R8: output stall with new inputs waiting
        @(negedge clk);
        res_ready = 1'b0;
        w1 = make_win(30, 9);
        w2 = make_win(200, 3);
        send_coef(16'd2048, 16'd512);
        send_win(w1);
        coef_valid = 1'b1; coef_gain = 16'd6144; coef_offset = 16'hFF00;
        win_valid = 1'b1; win_pix = w2;
        for (int i = 0; i < 3; i++) begin
            #1;
            chk("R8 res_valid held", int'(res_valid), 1);
            chk("R8 win_ready low", int'(win_ready), 0);
            check_window("R8 result held", 16'd2048, 16'd512, w1);
            @(posedge clk); @(negedge clk);
            coef_valid = 1'b0;
        end
        #1;
        chk("R8 pair kept", int'(coef_ready), 0);
        res_ready = 1'b1;
        @(posedge clk); @(negedge clk);
        win_valid = 1'b0;
        chk("R8 next result valid", int'(res_valid), 1);
        check_window("R8 next result", 16'd6144, 16'hFF00, w2);
        @(posedge clk); @(negedge clk);
        chk("R8 drained", int'(res_valid), 0);

        // Table stream: R2, R3, R4 per lane, R9 throughput
        for (int v = 0; v < NV; v++) begin
            sg[v] = TG[v];
            so[v] = TB[v];
            sw[v] = make_win(TBASE[v], TSTEP[v]);
        end
        run_stream(NV);

        repeat (3) @(posedge clk);
        summary();
    end
endmodule